// File: doc/BRIEF.md
# Banked GPIO Port Register File

This block gives a register bus direct control over a set of general purpose I/O lines. The lines are grouped into banks of a fixed width, and every bank owns two registers: an output-value register and a direction register. The direction bit of a line decides whether its pad is driven from the output-value bit or left floating so that the pad can be read. A read of the output-value register gives the output latch for driven lines and, for lines set as inputs, the pad level after two synchronizing flops.

Bank registers are not packed from address zero. The base of bank n is (n+1) times 8, so the first bank begins at 0x08, and any base that lands at 0x90 or higher moves up by 0x10 so that the window 0x90 to 0x9F stays free for interrupt registers that live elsewhere. The direction register of a bank sits 4 bytes above its output-value register. Any address that no bank claims reads as zero and swallows writes.

Top module: `gpio_bank_regfile`

## Requirements
- R1: After reset every direction bit is 1 (input), every output-value bit is 0, pad_oe is all zero and pad_out is all zero.
- R2: Bank n owns the output-value register at byte address base(n) = (n+1)*8 and the direction register at base(n)+4; no address selects more than one register.
- R3: A base that computes to 0x90 or above is raised by 0x10 (bank 17 output-value register at 0xA0, direction at 0xA4); addresses 0x90 to 0x9F select no register.
- R4: A direction bit of 1 makes the line an input (pad_oe low) and 0 makes it an output (pad_oe high); pad_oe follows a direction write from the clock edge that accepts the write.
- R5: pad_out carries each line's output-value bit, updated by the clock edge that accepts the write.
- R6: A read of an output-value register returns the output latch on bit positions whose line is an output and the pad level passed through two flops on positions whose line is an input, so a pad change is visible to a read accepted on the third rising edge after the change and not to one accepted on the second.
- R7: A read request is accepted on a rising edge; rdata holds the result and rvalid is high for exactly the following cycle.
- R8: Addresses that select no register (below 0x08, misaligned, inside the 0x90 to 0x9F window, or beyond the last bank) read as zero and leave every pad output unchanged when written.
- R9: Register bits above the lines a bank holds (bits 31 down to LINES_PER_BANK, and lines beyond NUM_LINES in the last bank) read as zero and ignore written values.
- R10: Line k belongs to bank k / LINES_PER_BANK at bit k mod LINES_PER_BANK (line 140 is bank 17 bit 4 with the defaults).
- R11: The number of banks is NUM_LINES / LINES_PER_BANK rounded up (20 banks, last bank holding 4 lines, with 156 lines of 8 per bank).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for addr and wdata |
| rd_en | input | 1 | Read strobe for addr |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid with rvalid |
| rvalid | output | 1 | High the cycle after an accepted read |
| pad_in | input | NUM_LINES | Pad levels seen by the block |
| pad_out | output | NUM_LINES | Values driven toward the pads |
| pad_oe | output | NUM_LINES | Per-line output enable, high drives the pad |

## Verification
Pad outputs react to a write at the edge that takes the write, so they are compared a short time after that edge and before the next one. Read data arrives one cycle after the edge that accepts the request, and the scoreboard pops each expected word only when rvalid is seen between edges, so the ordering of results is checked as well as their values. Input lines need two edges to pass the synchronizer; the bench issues one read on the second edge after a pad change, expecting the old level, and a second on the third, expecting the new one.

// File: rtl/gpio_regfile_pkg.sv
package gpio_regfile_pkg;

  localparam int unsigned BANK_STRIDE   = 8;
  localparam int unsigned DIR_OFFSET    = 4;
  localparam int unsigned IRQ_HOLE_BASE = 'h90;
  localparam int unsigned IRQ_HOLE_SIZE = 'h10;

  // Byte address of the output-value register of one bank.
  function automatic logic [31:0] bank_base_addr(input int unsigned bank);
    int unsigned base;
    base = (bank + 1) * BANK_STRIDE;
    if (base >= IRQ_HOLE_BASE) base = base + IRQ_HOLE_SIZE;
    return base[31:0];
  endfunction

  function automatic int unsigned bank_count(input int unsigned lines,
                                             input int unsigned per_bank);
    return (lines + per_bank - 1) / per_bank;
  endfunction

  // Number of real lines inside a given bank.
  function automatic int unsigned bank_width(input int unsigned lines,
                                             input int unsigned per_bank,
                                             input int unsigned bank);
    int unsigned left;
    left = lines - bank * per_bank;
    return (left < per_bank) ? left : per_bank;
  endfunction

  function automatic logic in_irq_hole(input logic [31:0] a);
    return (a >= IRQ_HOLE_BASE) && (a < IRQ_HOLE_BASE + IRQ_HOLE_SIZE);
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regfile_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 20,
  parameter int unsigned ADDR_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_BANKS-1:0] data_sel,
  output logic [NUM_BANKS-1:0] dir_sel,
  output logic                 hit
);

  always_comb begin
    data_sel = '0;
    dir_sel  = '0;
    for (int unsigned b = 0; b < NUM_BANKS; b++) begin
      if (addr == ADDR_W'(bank_base_addr(b)))
        data_sel[b] = 1'b1;
      if (addr == ADDR_W'(bank_base_addr(b) + DIR_OFFSET))
        dir_sel[b] = 1'b1;
    end
    hit = |{data_sel, dir_sel};
  end

  // R2: at most one register claims any address
  assert_single_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({data_sel, dir_sel}));

  // R3: the interrupt window is never claimed by a bank
  assert_hole_unmapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_irq_hole(32'(addr)) |-> !hit);

endmodule

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank #(
  parameter int unsigned LPB   = 8,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_data,
  input  logic             wr_dir,
  input  logic [LPB-1:0]   wdata,
  input  logic [WIDTH-1:0] pad_sync,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [LPB-1:0]   rd_data,
  output logic [LPB-1:0]   rd_dir
);

  logic [WIDTH-1:0] wr_val;
  logic [WIDTH-1:0] data_view;

  assign wr_val = wdata[WIDTH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '1;
    end else begin
      if (wr_data) out_q <= wr_val;
      if (wr_dir)  dir_q <= wr_val;
    end
  end

  // input lines show the synchronized pad, output lines the latch
  assign data_view = (dir_q & pad_sync) | (~dir_q & out_q);
  assign rd_data   = LPB'(data_view);
  assign rd_dir    = LPB'(dir_q);

  assert_dir_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> dir_q == $past(wdata[WIDTH-1:0]));

  assert_data_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data |=> out_q == $past(wdata[WIDTH-1:0]));

endmodule

// File: rtl/gpio_bank_regfile.sv
module gpio_bank_regfile
  import gpio_regfile_pkg::*;
#(
  parameter int unsigned NUM_LINES      = 156,
  parameter int unsigned LINES_PER_BANK = 8,
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned DATA_W         = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic                 rvalid,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe
);

  localparam int unsigned NUM_BANKS = bank_count(NUM_LINES, LINES_PER_BANK);

  logic [NUM_BANKS-1:0]      data_sel;
  logic [NUM_BANKS-1:0]      dir_sel;
  logic                      addr_hit;
  logic [NUM_LINES-1:0]      pad_sync;
  logic [LINES_PER_BANK-1:0] bank_rd_data [NUM_BANKS];
  logic [LINES_PER_BANK-1:0] bank_rd_dir  [NUM_BANKS];
  logic [LINES_PER_BANK-1:0] rd_sel_val;
  logic [DATA_W-1:0]         rdata_q;
  logic                      rvalid_q;
  logic                      wr_unmapped;
  logic                      rd_unmapped;

  gpio_addr_decode #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
  ) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .data_sel (data_sel),
    .dir_sel  (dir_sel),
    .hit      (addr_hit)
  );

  gpio_pad_sync #(
    .WIDTH (NUM_LINES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_in),
    .sync_out (pad_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int unsigned LO = b * LINES_PER_BANK;
    localparam int unsigned W  = bank_width(NUM_LINES, LINES_PER_BANK, b);
    logic [W-1:0] out_q;
    logic [W-1:0] dir_q;

    gpio_port_bank #(
      .LPB   (LINES_PER_BANK),
      .WIDTH (W)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_data  (wr_en & data_sel[b]),
      .wr_dir   (wr_en & dir_sel[b]),
      .wdata    (wdata[LINES_PER_BANK-1:0]),
      .pad_sync (pad_sync[LO +: W]),
      .out_q    (out_q),
      .dir_q    (dir_q),
      .rd_data  (bank_rd_data[b]),
      .rd_dir   (bank_rd_dir[b])
    );

    assign pad_out[LO +: W] = out_q;
    assign pad_oe[LO +: W]  = ~dir_q;
  end

  always_comb begin
    rd_sel_val = '0;
    for (int unsigned b = 0; b < NUM_BANKS; b++) begin
      if (data_sel[b]) rd_sel_val = rd_sel_val | bank_rd_data[b];
      if (dir_sel[b])  rd_sel_val = rd_sel_val | bank_rd_dir[b];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= DATA_W'(rd_sel_val);
    end
  end

  assign rdata       = rdata_q;
  assign rvalid      = rvalid_q;
  assign wr_unmapped = wr_en & ~addr_hit;
  assign rd_unmapped = rd_en & ~addr_hit;

  assert_rvalid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  assert_rvalid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);

  assert_unmapped_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_unmapped |=> rdata == '0);

  assert_unmapped_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmapped |=> $stable(pad_out) && $stable(pad_oe));

endmodule

// File: tb/test_gpio_bank_regfile.sv
module test_gpio_bank_regfile;

  localparam int NL  = 156;
  localparam int LPB = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [31:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rvalid;
  logic [NL-1:0] pad_in = '0;
  logic [NL-1:0] pad_out;
  logic [NL-1:0] pad_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  gpio_bank_regfile i_gpio_bank_regfile (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // bank address restated: linear below the window, shifted by 0x10 after it
  function automatic logic [31:0] addr_of(input int bank, input bit dir);
    int a;
    a = (bank < 17) ? 8 + 8 * bank : 24 + 8 * bank;
    return 32'(a + (dir ? 4 : 0));
  endfunction

  task automatic check(input string tag, input logic [159:0] got, input logic [159:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // driver: called at posedge+2, leaves at posedge+2
  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #2;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  // monitor: pops one expected word per rvalid, between edges
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R7: unexpected rvalid, rdata %h expected none", rdata);
      end else begin
        check(tag_q.pop_front(), 160'(rdata), 160'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NL-1:0] po;
    logic [NL-1:0] oe;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 pad_oe", 160'(pad_oe), 160'(0));
    check("R1 pad_out", 160'(pad_out), 160'(0));
    check("R7 rvalid idle", 160'(rvalid), 160'(0));
    rd(addr_of(0, 1), 32'hFF, "R1 dir bank0");
    rd(addr_of(0, 0), 32'h00, "R1 data bank0");
    // R11 R9: last bank (19) holds only 4 lines
    rd(addr_of(19, 1), 32'h0F, "R11 R9 dir last bank");
    rd(addr_of(20, 1), 32'h00, "R11 no bank 20");

    // R2 R4 R5: bank 0, lines 4..7 outputs
    wr(addr_of(0, 0), 32'hA5);
    wr(addr_of(0, 1), 32'h0F);
    check("R5 pad_out bank0", 160'(pad_out[7:0]), 160'(8'hA5));
    check("R4 pad_oe bank0", 160'(pad_oe[7:0]), 160'(8'hF0));
    pad_in[7:0] = 8'h06;
    idle(3);
    rd(addr_of(0, 0), 32'hA6, "R6 mixed read bank0");
    rd(addr_of(0, 1), 32'h0F, "R2 dir readback bank0");

    // R3 R10: bank 17 above the window; line 140 is bank 17 bit 4
    wr(addr_of(17, 0), 32'h5A);
    wr(addr_of(17, 1), 32'h00);
    check("R3 pad_out bank17", 160'(pad_out[143:136]), 160'(8'h5A));
    check("R10 line140 oe", 160'(pad_oe[140]), 160'(1));
    check("R10 line140 out", 160'(pad_out[140]), 160'(1));
    rd(32'hA0, 32'h5A, "R3 bank17 data at A0");
    rd(32'hA4, 32'h00, "R3 bank17 dir at A4");
    rd(addr_of(16, 1), 32'hFF, "R2 bank16 dir at 8C");

    // R3 R8: window and other unmapped addresses
    po = pad_out; oe = pad_oe;
    wr(32'h90, 32'hFFFF_FFFF);
    wr(32'h94, 32'h0000_0000);
    wr(32'h98, 32'h0000_0000);
    wr(32'h9C, 32'hFFFF_FFFF);
    wr(32'h00, 32'h0000_0000);
    wr(32'h04, 32'h0000_0000);
    wr(32'h0A, 32'h0000_0000);
    wr(32'hB8, 32'h0000_0000);
    check("R8 pads unchanged out", 160'(pad_out), 160'(po));
    check("R8 pads unchanged oe", 160'(pad_oe), 160'(oe));
    rd(32'h90, 32'h0, "R3 window 90 reads zero");
    rd(32'h9C, 32'h0, "R3 window 9C reads zero");
    rd(32'h04, 32'h0, "R8 addr 04 reads zero");
    rd(32'h09, 32'h0, "R8 misaligned reads zero");
    rd(32'hB8, 32'h0, "R8 beyond last reads zero");

    // R9: wide writes
    wr(addr_of(1, 1), 32'hFFFF_FF00);
    wr(addr_of(1, 0), 32'hFFFF_FFFF);
    check("R9 bank1 pad_out", 160'(pad_out[15:8]), 160'(8'hFF));
    rd(addr_of(1, 0), 32'hFF, "R9 bank1 upper bits zero");
    wr(addr_of(19, 1), 32'h0000_0000);
    wr(addr_of(19, 0), 32'hFFFF_FFFF);
    check("R9 last bank oe", 160'(pad_oe[155:152]), 160'(4'hF));
    check("R9 last bank out", 160'(pad_out[155:152]), 160'(4'hF));
    rd(addr_of(19, 0), 32'h0F, "R9 last bank data");
    rd(addr_of(19, 1), 32'h00, "R9 last bank dir");

    // R6: two-flop latency on bank 2 (all inputs)
    pad_in[23:16] = 8'h3C;
    idle(1);
    rd(addr_of(2, 0), 32'h00, "R6 second edge sees old");
    rd(addr_of(2, 0), 32'h3C, "R6 third edge sees new");
    // R4: turning bank 2 to output hides the pad
    wr(addr_of(2, 1), 32'h00);
    check("R4 bank2 oe", 160'(pad_oe[23:16]), 160'(8'hFF));
    rd(addr_of(2, 0), 32'h00, "R4 output line reads latch");

    idle(3);
    check("R7 all reads returned", 160'(exp_q.size()), 160'(0));
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule